// File: doc/BRIEF.md
# Single-Error-Correcting Memory Word Codec

This block keeps 8-bit data words safe while they sit in a small memory array. On a write, the byte is expanded into a 12-bit codeword. Four even-parity check bits sit at the power-of-two positions, numbered 1, 2, 4 and 8, of a word whose positions run from 1 to 12. An optional fault mask is XORed into the codeword as it is stored, so that bit upsets can be planted on purpose. On a read, the stored word comes out of a registered port one cycle after the request. The four check groups are then recomputed over it to form a syndrome.

A zero syndrome passes the data through untouched. A syndrome from 1 to 12 is the number of the upset position, and that bit is inverted before the data is extracted. Syndromes 13 to 15 name positions that do not exist. Such a read is flagged uncorrectable, and its data is returned exactly as stored.

Top module: `secCodecMem`

## Requirements
- R1: The stored codeword, with bit k-1 of `rdRaw` holding position k, carries the data with d[7] at position 3, d[6] at 5, d[5] at 6, d[4] at 7, d[3] at 9, d[2] at 10, d[1] at 11 and d[0] at 12. The check bit at position 2^i makes the count of ones even across all positions whose index has bit i set.
- R2: A read of a word stored without any flip gives syndrome 0000. Both flags are low, and `rdData` equals the byte written.
- R3: A read of a word with exactly one flipped position k (1..12) gives syndrome k, with position 1 giving 0001 and position 5 giving 0101. `rdCorrected` is high, `rdUncorrectable` is low, and `rdData` equals the byte written.
- R4: A syndrome of 13, 14 or 15 drives `rdUncorrectable` high and `rdCorrected` low. `rdData` is then the data positions of the stored word without any correction.
- R5: A read request (`memEn`=1, `wrEn`=0) at one clock edge makes `rdValid` high, with the addressed word on `rdRaw`, right after the next edge. `rdValid` is high only in that cycle.
- R6: While `memEn` is low, no word is written, `rdValid` stays low and `rdRaw` holds its value.
- R7: A write (`memEn`=1, `wrEn`=1) stores the encoded byte XORed with `flipMask`, where bit k-1 of the mask flips position k. A write cycle raises no `rdValid`.
- R8: After reset, `rdValid`, `rdRaw` and therefore `rdData`, `rdSyndrome` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memEn | input | 1 | Enables one access in this cycle |
| wrEn | input | 1 | 1 = write, 0 = read, when enabled |
| addr | input | ADDR_W | Word address |
| wrData | input | 8 | Byte to encode and store |
| flipMask | input | 12 | Fault injection mask XORed into the stored word |
| rdValid | output | 1 | Read result present this cycle |
| rdRaw | output | 12 | Codeword as read from the array |
| rdData | output | 8 | Corrected data byte |
| rdSyndrome | output | 4 | Recomputed syndrome |
| rdCorrected | output | 1 | A single position was repaired |
| rdUncorrectable | output | 1 | Syndrome names a nonexistent position |

## Verification
The hardest case to reach is the uncorrectable path. A single upset can never produce a syndrome above 12, so the decoder never sees one from ordinary stimulus. The bench stores words with two positions flipped together, chosen so that their indices XOR to 13, 14 and 15 (4 with 9, 6 with 8, 7 with 8). Each of the twelve single flips is also planted through the mask, alongside a clean write. A scoreboard checks each result against a separately written encoder.

// File: rtl/secPkg.sv
package secPkg;
  localparam int DATA_W = 8;
  localparam int SYN_W  = 4;
  localparam int CODE_W = DATA_W + SYN_W;

  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } ctrlStrobesT;

  function automatic logic isPow2(input int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  // position (1-based) that carries data bit di; MSB goes lowest
  function automatic int dataPos(input int di);
    int slot;
    slot = 0;
    for (int pos = 1; pos <= CODE_W; pos++) begin
      if (!isPow2(pos)) begin
        if (slot == DATA_W - 1 - di) return pos;
        slot++;
      end
    end
    return 0;
  endfunction
endpackage

// File: rtl/secEncoder.sv
module secEncoder
  import secPkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] placed;

  always_comb begin
    placed = '0;
    for (int di = 0; di < DATA_W; di++) placed[dataPos(di) - 1] = data[di];
  end

  always_comb begin
    code = placed;
    for (int i = 0; i < SYN_W; i++) begin
      logic par;
      par = 1'b0;
      for (int pos = 1; pos <= CODE_W; pos++)
        if (pos[i] && !isPow2(pos)) par = par ^ placed[pos - 1];
      code[(1 << i) - 1] = par;
    end
  end
endmodule

// File: rtl/secDecoder.sv
module secDecoder
  import secPkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output logic [SYN_W-1:0]  syndrome,
  output logic              corrected,
  output logic              uncorrectable
);
  logic [CODE_W-1:0] fixedWord;
  logic              inRange;

  always_comb begin
    for (int i = 0; i < SYN_W; i++) begin
      logic acc;
      acc = 1'b0;
      for (int pos = 1; pos <= CODE_W; pos++)
        if (pos[i]) acc = acc ^ code[pos - 1];
      syndrome[i] = acc;
    end
  end

  assign inRange       = (syndrome != '0) && (syndrome <= SYN_W'(CODE_W));
  assign corrected     = inRange;
  assign uncorrectable = (syndrome != '0) && !inRange;

  always_comb begin
    for (int pos = 1; pos <= CODE_W; pos++)
      fixedWord[pos - 1] = code[pos - 1] ^ (inRange && (syndrome == SYN_W'(pos)));
    for (int di = 0; di < DATA_W; di++) data[di] = fixedWord[dataPos(di) - 1];
  end
endmodule

// File: rtl/secCtrl.sv
module secCtrl
  import secPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        memEn,
  input  logic        wrEn,
  output ctrlStrobesT strobes,
  output logic        rdValid
);
  assign strobes.wrStb = memEn && wrEn;
  assign strobes.rdStb = memEn && !wrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobes.rdStb;
  end
endmodule

// File: rtl/secDatapath.sv
module secDatapath
  import secPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CODE_W-1:0] flipMask,
  output logic [CODE_W-1:0] rdRaw,
  output logic [DATA_W-1:0] rdData,
  output logic [SYN_W-1:0]  rdSyndrome,
  output logic              rdCorrected,
  output logic              rdUncorrectable
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CODE_W-1:0] encWord;
  logic [CODE_W-1:0] store [DEPTH];

  secEncoder i_enc (.data(wrData), .code(encWord));

  always_ff @(posedge clk) begin
    if (strobes.wrStb) store[addr] <= encWord ^ flipMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdRaw <= '0;
    else if (strobes.rdStb) rdRaw <= store[addr];
  end

  secDecoder i_dec (
    .code(rdRaw), .data(rdData), .syndrome(rdSyndrome),
    .corrected(rdCorrected), .uncorrectable(rdUncorrectable)
  );
endmodule

// File: rtl/secCodecMem.sv
module secCodecMem
  import secPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [11:0]       flipMask,
  output logic              rdValid,
  output logic [11:0]       rdRaw,
  output logic [7:0]        rdData,
  output logic [3:0]        rdSyndrome,
  output logic              rdCorrected,
  output logic              rdUncorrectable
);
  ctrlStrobesT strobes;

  secCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .memEn(memEn), .wrEn(wrEn),
    .strobes(strobes), .rdValid(rdValid)
  );

  secDatapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr),
    .wrData(wrData), .flipMask(flipMask), .rdRaw(rdRaw),
    .rdData(rdData), .rdSyndrome(rdSyndrome),
    .rdCorrected(rdCorrected), .rdUncorrectable(rdUncorrectable)
  );
endmodule

// File: rtl/secCodecChecker.sv
module secCodecChecker (
  input logic        clk,
  input logic        rstN,
  input logic        memEn,
  input logic        wrEn,
  input logic        rdValid,
  input logic [11:0] rdRaw,
  input logic [3:0]  rdSyndrome,
  input logic        rdCorrected,
  input logic        rdUncorrectable
);
  p_read_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !wrEn) |=> rdValid);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !memEn |=> (!rdValid && $stable(rdRaw)));

  p_write_no_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && wrEn) |=> !rdValid);

  p_uncorr_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdUncorrectable |-> (rdSyndrome >= 4'd13 && !rdCorrected));

  p_corr_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdCorrected |-> (rdSyndrome != 4'd0 && rdSyndrome <= 4'd12));

  p_clean_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdSyndrome == 4'd0) |-> (!rdCorrected && !rdUncorrectable));
endmodule

bind secCodecMem secCodecChecker i_chk (.*);

// File: tb/test_secCodecMem.sv
`timescale 1ns/1ps
module test_secCodecMem;
  typedef struct {
    logic [7:0]  data;
    logic [3:0]  syn;
    logic        corr;
    logic        unc;
    logic [11:0] raw;
    int          issue;
    string       tag;
  } expItemT;

  logic clk = 0, rstN = 0, memEn = 0, wrEn = 0;
  logic [3:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [11:0] flipMask = '0;
  logic rdValid, rdCorrected, rdUncorrectable;
  logic [11:0] rdRaw;
  logic [7:0]  rdData;
  logic [3:0]  rdSyndrome;

  int checks = 0, errors = 0, cycle = 0;
  bit done = 0;
  expItemT sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  secCodecMem i_secCodecMem (
    .clk(clk), .rstN(rstN), .memEn(memEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .flipMask(flipMask), .rdValid(rdValid), .rdRaw(rdRaw),
    .rdData(rdData), .rdSyndrome(rdSyndrome), .rdCorrected(rdCorrected),
    .rdUncorrectable(rdUncorrectable)
  );

  function automatic logic [11:0] refEncode(input logic [7:0] d);
    logic [11:0] w;
    w = '0;
    w[2] = d[7]; w[4] = d[6]; w[5] = d[5]; w[6] = d[4];
    w[8] = d[3]; w[9] = d[2]; w[10] = d[1]; w[11] = d[0];
    w[0] = d[7] ^ d[6] ^ d[4] ^ d[3] ^ d[1];
    w[1] = d[7] ^ d[5] ^ d[4] ^ d[2] ^ d[1];
    w[3] = d[6] ^ d[5] ^ d[4] ^ d[0];
    w[7] = d[3] ^ d[2] ^ d[1] ^ d[0];
    return w;
  endfunction

  function automatic logic [7:0] refExtract(input logic [11:0] w);
    return {w[2], w[4], w[5], w[6], w[8], w[9], w[10], w[11]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic writeWord(input logic [3:0] a, input logic [7:0] d,
                           input logic [11:0] m, input bit en);
    @(negedge clk);
    memEn = en; wrEn = 1; addr = a; wrData = d; flipMask = m;
    @(negedge clk);
    memEn = 0; wrEn = 0; flipMask = '0;
  endtask

  task automatic readWord(input logic [3:0] a, input expItemT e);
    @(negedge clk);
    memEn = 1; wrEn = 0; addr = a;
    e.issue = cycle;
    sb.push_back(e);
    @(negedge clk);
    memEn = 0;
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (sb.size() == 0) check(0, "R5", "unexpected rdValid", 1, 0);
      else begin
        expItemT e;
        e = sb.pop_front();
        check(cycle == e.issue + 1, "R5", "latency", cycle - e.issue, 1);
        check(rdRaw == e.raw, "R1/R7", "stored word", rdRaw, e.raw);
        check(rdSyndrome == e.syn, e.tag, "syndrome", rdSyndrome, e.syn);
        check(rdCorrected == e.corr, e.tag, "corrected", rdCorrected, e.corr);
        check(rdUncorrectable == e.unc, e.tag, "uncorrectable", rdUncorrectable, e.unc);
        check(rdData == e.data, e.tag, "data", rdData, e.data);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    expItemT e;
    logic [11:0] heldRaw;
    logic [11:0] m;
    logic [7:0] patterns [4] = '{8'hC4, 8'h00, 8'hFF, 8'hA5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check(rdValid == 0 && rdRaw == 0 && rdData == 0, "R8", "reset outputs",
          {rdValid, rdRaw, rdData}, 0);
    check(rdSyndrome == 0 && !rdCorrected && !rdUncorrectable, "R8", "reset flags",
          {rdSyndrome, rdCorrected, rdUncorrectable}, 0);
    rstN = 1;

    // R1, R2: clean words
    for (int i = 0; i < 4; i++) begin
      writeWord(4'(i), patterns[i], '0, 1);
      e.data = patterns[i]; e.syn = 0; e.corr = 0; e.unc = 0;
      e.raw = refEncode(patterns[i]); e.tag = "R2";
      readWord(4'(i), e);
    end

    // R3, R7: each single position flipped
    for (int k = 1; k <= 12; k++) begin
      logic [7:0] d;
      d = 8'h3C ^ 8'(k * 37);
      m = 12'(1) << (k - 1);
      writeWord(4'(k + 3), d, m, 1);
      e.data = d; e.syn = 4'(k); e.corr = 1; e.unc = 0;
      e.raw = refEncode(d) ^ m; e.tag = "R3";
      readWord(4'(k + 3), e);
    end

    // R4: double flips whose indices XOR to 13, 14, 15
    for (int j = 0; j < 3; j++) begin
      int pa, pb;
      pa = (j == 0) ? 4 : (j == 1) ? 6 : 7;
      pb = (j == 0) ? 9 : 8;
      m = (12'(1) << (pa - 1)) | (12'(1) << (pb - 1));
      writeWord(4'(j), 8'h5A, m, 1);
      e.raw = refEncode(8'h5A) ^ m;
      e.data = refExtract(e.raw); e.syn = 4'(pa ^ pb); e.corr = 0; e.unc = 1;
      e.tag = "R4";
      readWord(4'(j), e);
    end

    // R6: disabled write leaves the word, disabled cycle raises nothing
    writeWord(4'd15, 8'h96, '0, 1);
    writeWord(4'd15, 8'h11, '0, 0);
    e.data = 8'h96; e.syn = 0; e.corr = 0; e.unc = 0;
    e.raw = refEncode(8'h96); e.tag = "R6";
    readWord(4'd15, e);
    @(negedge clk);
    heldRaw = rdRaw;
    memEn = 0; wrEn = 0; addr = 4'd0;
    @(negedge clk);
    check(!rdValid, "R6", "rdValid while disabled", rdValid, 0);
    check(rdRaw == heldRaw, "R6", "rdRaw held", rdRaw, heldRaw);

    // R7: write cycle raises no rdValid
    @(negedge clk);
    memEn = 1; wrEn = 1; addr = 4'd14; wrData = 8'h01;
    @(negedge clk);
    memEn = 0; wrEn = 0;
    check(!rdValid, "R7", "rdValid after write", rdValid, 0);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R5", "pending reads", sb.size(), 0);
    finishRun();
  end
endmodule